// File: doc/BRIEF.md
# Thermostat Alert with Consecutive-Fault Filter

This block watches the stream of finished temperature conversions and decides when a thermal alert line should change state. Each new result is compared, as a signed 12-bit value using every bit, against a high threshold and a low threshold. A change of the alert needs a programmed run of back-to-back out-of-range results (1, 2, 4 or 6), so a single noisy sample cannot flip the line. The comparison happens only on the cycle the conversion strobe is high.

Two behaviours are selectable. In level (comparator) mode the alert follows the temperature with hysteresis: it turns on at or above the high threshold and turns off below the low threshold. In event (interrupt) mode the alert latches on a qualified crossing and stays on until software reads any register or the block wins an alert-response arbitration. After that the block waits for the opposite crossing, so the crossings alternate between high and low. A cause flag tells an alert-response responder whether the high or the low threshold raised the alert. The level of the output pin is selectable. Entering shutdown or receiving a general-call reset clears the alert. The register file that holds the thresholds and configuration sits outside this block and restores its own reset values.

Top module: `thermo_alert`

## Requirements
- R1: The fault-count code `cfg_fq` selects how many consecutive qualifying conversions change the alert: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4 and 2'b11 needs 6.
- R2: In level mode (`cfg_int_mode`=0), with the alert off, a qualified run of conversions at or above `lim_hi` turns the alert on, and `ar_status` reads 1 one clock after the qualifying strobe.
- R3: In level mode the alert turns off only after a qualified run of conversions below `lim_lo`. A result equal to `lim_lo` does not count. `reg_rd_pulse` and `ar_win_pulse` have no effect in this mode.
- R4: In event mode (`cfg_int_mode`=1) a qualified high run turns the alert on. It stays on, and conversions are ignored, until `reg_rd_pulse` or `ar_win_pulse` clears it.
- R5: After an event-mode clear the block arms on the low threshold. A qualified run below `lim_lo` turns the alert on with `ar_status`=0. A cycle without a win or a read (lost arbitration) leaves it on. The next clear re-arms on the high threshold.
- R6: A rising edge of `shutdown` clears the alert and the fault count. A conversion strobed while `shutdown` stays high is still evaluated.
- R7: `gc_reset` clears the alert, `ar_status` and the fault count, and arms the block on the high threshold.
- R8: `cfg_pol`=0 drives `alert_pin` low when the alert is on. `cfg_pol`=1 drives it high when the alert is on. The pin follows `cfg_pol` without waiting for a clock.
- R9: The comparisons are signed two's complement over the full 12 bits at every resolution. The least significant bit of a threshold decides the outcome.
- R10: A strobed conversion that does not meet the armed condition resets the run of consecutive faults to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe: a new conversion result is on `conv_temp` |
| conv_temp | input | 12 | Conversion result, signed, 1/16 degree per LSB |
| lim_hi | input | 12 | High threshold, signed |
| lim_lo | input | 12 | Low threshold, signed |
| cfg_int_mode | input | 1 | 0 = level mode, 1 = event mode |
| cfg_pol | input | 1 | Active level of `alert_pin` |
| cfg_fq | input | 2 | Consecutive-fault count code |
| reg_rd_pulse | input | 1 | One-cycle pulse: some register was read |
| ar_win_pulse | input | 1 | One-cycle pulse: alert-response arbitration won |
| shutdown | input | 1 | Shutdown level; its rising edge clears the alert |
| gc_reset | input | 1 | General-call reset, synchronous |
| alert_pin | output | 1 | Alert level after polarity |
| ar_status | output | 1 | 1 while an alert raised by the high threshold is on |

## Verification
The properties assume that reset is applied before the first conversion and that the read, win and general-call inputs are single-cycle strobes qualified by the surrounding bus logic. The hold-in-level-mode property also assumes that the mode bit does not toggle while a result is being filtered. The bench drives every input on the falling clock edge. It changes the fault count, mode and thresholds only when the run counter has just been emptied by a qualification, a break or a reset, so each run starts from a known count.

// File: rtl/thermo_alert_pkg.sv
package thermo_alert_pkg;

   // Width of the consecutive-fault counter; must hold the largest run (6).
   localparam int RUN_CW = 3;

   typedef enum logic [1:0] {
      ST_ARM_HI = 2'b00,
      ST_ON_HI  = 2'b01,
      ST_ARM_LO = 2'b10,
      ST_ON_LO  = 2'b11
   } alert_st_e;

   // Decode of the run-length code into the number of conversions needed.
   function automatic logic [RUN_CW-1:0] run_need(input logic [1:0] code);
      logic [RUN_CW-1:0] n;
      case (code)
         2'b00:   n = RUN_CW'(1);
         2'b01:   n = RUN_CW'(2);
         2'b10:   n = RUN_CW'(4);
         default: n = RUN_CW'(6);
      endcase
      return n;
   endfunction

endpackage

// File: rtl/thermo_cmp.sv
module thermo_cmp #(
   parameter int TEMP_W     = 12,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [TEMP_W-1:0] temp,
   input  logic [TEMP_W-1:0] lim_hi,
   input  logic [TEMP_W-1:0] lim_lo,
   output logic              at_or_above_hi,
   output logic              below_lo
);

   generate
      if (TEMP_W < 2) begin : g_bad_width
         $error("thermo_cmp: TEMP_W must be at least 2");
      end

      if (SIGNED_CMP) begin : g_signed
         always_comb begin
            at_or_above_hi = $signed(temp) >= $signed(lim_hi);
            below_lo       = $signed(temp) <  $signed(lim_lo);
         end
      end else begin : g_unsigned
         always_comb begin
            at_or_above_hi = temp >= lim_hi;
            below_lo       = temp <  lim_lo;
         end
      end
   endgenerate

endmodule

// File: rtl/thermo_fault_queue.sv
module thermo_fault_queue
   import thermo_alert_pkg::*;
#(
   parameter int CW = RUN_CW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          sample,
   input  logic          fault,
   input  logic [CW-1:0] need,
   output logic          qual
);

   localparam int SUM_W = CW + 1;

   logic [CW-1:0]    run_q;
   logic [SUM_W-1:0] run_next;

   generate
      if (CW < 3) begin : g_bad_cw
         $error("thermo_fault_queue: counter too narrow for a run of 6");
      end
   endgenerate

   assign run_next = {1'b0, run_q} + SUM_W'(1);
   assign qual     = sample && fault && (run_next >= {1'b0, need});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (clr) begin
         run_q <= '0;
      end else if (sample) begin
         if (fault && !qual) run_q <= run_next[CW-1:0];
         else                run_q <= '0;
      end
   end

   // A strobed non-fault result empties the run.
   p_break_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && !fault && !clr) |=> (run_q == '0));

   // A general clear empties the run.
   p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (run_q == '0));

endmodule

// File: rtl/thermo_alert_fsm.sv
module thermo_alert_fsm
   import thermo_alert_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic int_mode,
   input  logic conv_valid,
   input  logic qual,
   input  logic rd_pulse,
   input  logic win_pulse,
   input  logic shutdown,
   input  logic gc_reset,
   output logic watch_lo,
   output logic count_en,
   output logic run_clr,
   output logic active,
   output logic hi_cause
);

   alert_st_e st_q, st_d;
   logic      sd_q;
   logic      kill;
   logic      ext_clr;

   assign kill    = gc_reset || (shutdown && !sd_q);
   assign ext_clr = int_mode && (rd_pulse || win_pulse);
   assign run_clr = kill;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_ARM_HI: if (qual) st_d = ST_ON_HI;
         ST_ON_HI: begin
            if (int_mode) begin
               if (ext_clr) st_d = ST_ARM_LO;
            end else if (qual) begin
               st_d = ST_ARM_HI;
            end
         end
         ST_ARM_LO: begin
            if (!int_mode)  st_d = ST_ARM_HI;
            else if (qual)  st_d = ST_ON_LO;
         end
         ST_ON_LO: begin
            if (!int_mode || ext_clr) st_d = ST_ARM_HI;
         end
         default: st_d = ST_ARM_HI;
      endcase
      if (kill) st_d = ST_ARM_HI;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_ARM_HI;
         sd_q <= 1'b0;
      end else begin
         st_q <= st_d;
         sd_q <= shutdown;
      end
   end

   always_comb begin
      watch_lo = (st_q == ST_ARM_LO) || ((st_q == ST_ON_HI) && !int_mode);
      count_en = (st_q == ST_ARM_HI)
               || ((st_q == ST_ARM_LO) && int_mode)
               || ((st_q == ST_ON_HI) && !int_mode);
      active   = (st_q == ST_ON_HI) || (st_q == ST_ON_LO);
      hi_cause = (st_q == ST_ON_HI);
   end

   // The alert only turns on as the result of a strobed conversion.
   p_on_needs_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(conv_valid));

   // Level mode: without a conversion, reads and wins leave the alert on.
   p_level_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_mode && active && !conv_valid && !gc_reset && !shutdown) |=> active);

   // Event mode: a read or a win clears the alert.
   p_event_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode && active && (rd_pulse || win_pulse)) |=> !active);

   // Entering shutdown clears the alert.
   p_shutdown_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown) |=> !active);

   // General-call reset clears alert and cause.
   p_gc_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gc_reset |=> (!active && !hi_cause));

endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
   import thermo_alert_pkg::*;
#(
   parameter int TEMP_W     = 12,
   parameter int FQ_W       = 2,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_valid,
   input  logic [TEMP_W-1:0] conv_temp,
   input  logic [TEMP_W-1:0] lim_hi,
   input  logic [TEMP_W-1:0] lim_lo,
   input  logic              cfg_int_mode,
   input  logic              cfg_pol,
   input  logic [FQ_W-1:0]   cfg_fq,
   input  logic              reg_rd_pulse,
   input  logic              ar_win_pulse,
   input  logic              shutdown,
   input  logic              gc_reset,
   output logic              alert_pin,
   output logic              ar_status
);

   localparam int CW = RUN_CW;

   logic          at_hi, below_lo;
   logic          watch_lo, count_en, run_clr;
   logic          qual, alert_active;
   logic [CW-1:0] need;

   generate
      if (FQ_W != 2) begin : g_bad_fq
         $error("thermo_alert: FQ_W must be 2");
      end
   endgenerate

   assign need = run_need(cfg_fq);

   thermo_cmp #(
      .TEMP_W     (TEMP_W),
      .SIGNED_CMP (SIGNED_CMP)
   ) u_cmp (
      .temp           (conv_temp),
      .lim_hi         (lim_hi),
      .lim_lo         (lim_lo),
      .at_or_above_hi (at_hi),
      .below_lo       (below_lo)
   );

   thermo_fault_queue #(.CW(CW)) u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (run_clr),
      .sample (conv_valid && count_en),
      .fault  (watch_lo ? below_lo : at_hi),
      .need   (need),
      .qual   (qual)
   );

   thermo_alert_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .int_mode   (cfg_int_mode),
      .conv_valid (conv_valid),
      .qual       (qual),
      .rd_pulse   (reg_rd_pulse),
      .win_pulse  (ar_win_pulse),
      .shutdown   (shutdown),
      .gc_reset   (gc_reset),
      .watch_lo   (watch_lo),
      .count_en   (count_en),
      .run_clr    (run_clr),
      .active     (alert_active),
      .hi_cause   (ar_status)
   );

   assign alert_pin = cfg_pol ? alert_active : !alert_active;

   // The pin only moves when the alert state or the polarity moves.
   p_pin_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(cfg_pol) && $stable(alert_active)) |-> $stable(alert_pin));

   // A high-caused alert is always an active alert.
   p_cause_implies_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ar_status |-> alert_active);

endmodule

// File: tb/thermo_alert_bench.sv
`timescale 1ns/1ps
module thermo_alert_bench;

   localparam logic [1:0] OP_CONV = 2'd0;
   localparam logic [1:0] OP_READ = 2'd1;
   localparam logic [1:0] OP_WIN  = 2'd2;
   localparam logic [1:0] OP_IDLE = 2'd3;
   localparam int         NVEC    = 32;

   // {mode, fq, pol, op, temp, exp_pin, exp_status}; hi = 0x500, lo = 0x4B0
   localparam logic [19:0] TBL [NVEC] = '{
      {1'b0,2'd1,1'b1,OP_CONV,12'h500,1'b0,1'b0}, // R1 first of two
      {1'b0,2'd1,1'b1,OP_CONV,12'h4FF,1'b0,1'b0}, // R10 streak broken
      {1'b0,2'd1,1'b1,OP_CONV,12'h500,1'b0,1'b0}, // R10 restart
      {1'b0,2'd1,1'b1,OP_CONV,12'h600,1'b1,1'b1}, // R2 on
      {1'b0,2'd1,1'b1,OP_READ,12'h000,1'b1,1'b1}, // R3 read ignored
      {1'b0,2'd1,1'b1,OP_WIN ,12'h000,1'b1,1'b1}, // R3 win ignored
      {1'b0,2'd1,1'b1,OP_CONV,12'h4B0,1'b1,1'b1}, // R3 equal to lo
      {1'b0,2'd1,1'b1,OP_CONV,12'h4AF,1'b1,1'b1}, // R3 one below
      {1'b0,2'd1,1'b1,OP_CONV,12'h4AF,1'b0,1'b0}, // R3 off
      {1'b0,2'd3,1'b1,OP_CONV,12'h7FF,1'b0,1'b0}, // R1 1 of 6
      {1'b0,2'd3,1'b1,OP_CONV,12'h7FF,1'b0,1'b0},
      {1'b0,2'd3,1'b1,OP_CONV,12'h7FF,1'b0,1'b0},
      {1'b0,2'd3,1'b1,OP_CONV,12'h7FF,1'b0,1'b0},
      {1'b0,2'd3,1'b1,OP_CONV,12'h7FF,1'b0,1'b0}, // R1 5 of 6
      {1'b0,2'd3,1'b1,OP_CONV,12'h7FF,1'b1,1'b1}, // R1 6 of 6
      {1'b0,2'd0,1'b1,OP_CONV,12'h000,1'b0,1'b0}, // R1 single low
      {1'b1,2'd2,1'b0,OP_CONV,12'h500,1'b1,1'b0}, // R4 1 of 4
      {1'b1,2'd2,1'b0,OP_CONV,12'h500,1'b1,1'b0},
      {1'b1,2'd2,1'b0,OP_CONV,12'h500,1'b1,1'b0},
      {1'b1,2'd2,1'b0,OP_CONV,12'h500,1'b0,1'b1}, // R4 on, active low
      {1'b1,2'd2,1'b0,OP_CONV,12'h000,1'b0,1'b1}, // R4 conversion ignored
      {1'b1,2'd2,1'b0,OP_READ,12'h000,1'b1,1'b0}, // R4 read clears
      {1'b1,2'd2,1'b0,OP_CONV,12'h800,1'b1,1'b0}, // R5 armed low, R9 signed
      {1'b1,2'd2,1'b0,OP_CONV,12'h800,1'b1,1'b0},
      {1'b1,2'd2,1'b0,OP_CONV,12'h800,1'b1,1'b0},
      {1'b1,2'd2,1'b0,OP_CONV,12'h800,1'b0,1'b0}, // R5 on, low cause
      {1'b1,2'd2,1'b0,OP_IDLE,12'h000,1'b0,1'b0}, // R5 lost arbitration
      {1'b1,2'd2,1'b0,OP_WIN ,12'h000,1'b1,1'b0}, // R5 win clears
      {1'b1,2'd2,1'b0,OP_CONV,12'h7FF,1'b1,1'b0}, // R5 re-armed high
      {1'b1,2'd2,1'b0,OP_CONV,12'h7FF,1'b1,1'b0},
      {1'b1,2'd2,1'b0,OP_CONV,12'h7FF,1'b1,1'b0},
      {1'b1,2'd2,1'b0,OP_CONV,12'h7FF,1'b0,1'b1}  // R5 high cause again
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        conv_valid, cfg_int_mode, cfg_pol;
   logic [11:0] conv_temp, lim_hi, lim_lo;
   logic [1:0]  cfg_fq;
   logic        reg_rd_pulse, ar_win_pulse, shutdown, gc_reset;
   logic        alert_pin, ar_status;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   thermo_alert u_thermo_alert (
      .clk          (clk),
      .rst_n        (rst_n),
      .conv_valid   (conv_valid),
      .conv_temp    (conv_temp),
      .lim_hi       (lim_hi),
      .lim_lo       (lim_lo),
      .cfg_int_mode (cfg_int_mode),
      .cfg_pol      (cfg_pol),
      .cfg_fq       (cfg_fq),
      .reg_rd_pulse (reg_rd_pulse),
      .ar_win_pulse (ar_win_pulse),
      .shutdown     (shutdown),
      .gc_reset     (gc_reset),
      .alert_pin    (alert_pin),
      .ar_status    (ar_status)
   );

   task automatic chk(input string req, input logic exp_pin, input logic exp_st);
      checks++;
      if (alert_pin !== exp_pin || ar_status !== exp_st) begin
         fails++;
         $display("FAIL %s: pin=%b status=%b expected pin=%b status=%b",
                  req, alert_pin, ar_status, exp_pin, exp_st);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic apply(input logic [1:0] op, input logic [11:0] t);
      conv_temp    = t;
      conv_valid   = (op == OP_CONV);
      reg_rd_pulse = (op == OP_READ);
      ar_win_pulse = (op == OP_WIN);
      @(posedge clk);
      @(negedge clk);
      conv_valid   = 1'b0;
      reg_rd_pulse = 1'b0;
      ar_win_pulse = 1'b0;
   endtask

   task automatic pulse_gc();
      gc_reset = 1'b1;
      @(posedge clk);
      @(negedge clk);
      gc_reset = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; conv_valid = 1'b0; conv_temp = '0;
      lim_hi = 12'h500; lim_lo = 12'h4B0;
      cfg_int_mode = 1'b0; cfg_pol = 1'b1; cfg_fq = 2'd1;
      reg_rd_pulse = 1'b0; ar_win_pulse = 1'b0; shutdown = 1'b0; gc_reset = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R8 reset, active high", 1'b0, 1'b0);
      cfg_pol = 1'b0; #1;
      chk("R8 reset, active low", 1'b1, 1'b0);
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         logic [19:0] v;
         v = TBL[i];
         cfg_int_mode = v[19];
         cfg_fq       = v[18:17];
         cfg_pol      = v[16];
         apply(v[15:14], v[13:2]);
         chk($sformatf("vector %0d", i), v[1], v[0]);
      end

      // Fresh start for directed cases
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      cfg_int_mode = 1'b0; cfg_pol = 1'b1; cfg_fq = 2'd0;
      lim_hi = 12'h501; lim_lo = 12'h4B0;

      apply(OP_CONV, 12'h500);
      chk("R9 one LSB under hi", 1'b0, 1'b0);
      apply(OP_CONV, 12'h501);
      chk("R9 equal to hi", 1'b1, 1'b1);
      lim_lo = 12'h000;
      apply(OP_CONV, 12'hFFF);
      chk("R9 -1 below 0", 1'b0, 1'b0);

      apply(OP_CONV, 12'h7FF);
      cfg_pol = 1'b0; #1;
      chk("R8 active low while on", 1'b0, 1'b1);
      cfg_pol = 1'b1; #1;
      chk("R8 active high while on", 1'b1, 1'b1);
      @(negedge clk);

      pulse_gc();
      chk("R7 gc clears alert", 1'b0, 1'b0);
      cfg_fq = 2'd1;
      apply(OP_CONV, 12'h7FF);
      chk("R7 run of one", 1'b0, 1'b0);
      pulse_gc();
      apply(OP_CONV, 12'h7FF);
      chk("R7 gc emptied run", 1'b0, 1'b0);
      apply(OP_CONV, 12'h7FF);
      chk("R1 second of two", 1'b1, 1'b1);

      shutdown = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R6 shutdown entry clears", 1'b0, 1'b0);
      cfg_fq = 2'd0;
      apply(OP_CONV, 12'h7FF);
      chk("R6 conversion during shutdown", 1'b1, 1'b1);
      shutdown = 1'b0;
      @(negedge clk);
      chk("R6 leaving shutdown keeps alert", 1'b1, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule